// File: doc/BRIEF.md
# Hashed Page Table Group Index Generator

This block turns a translation request into the coordinates of a page-table entry group in a hashed page table. From a segment identifier, an effective address, a segment-size select and a page-shift code, it forms the virtual page number, which is kept with its low 12 bits dropped. It then folds that number into a primary hash and derives the secondary hash from it. Finally it masks the primary hash down to a group index for a table of the configured size and converts that index into a byte offset. Each group holds eight entries, and each entry is two 64-bit words, so a group spans 128 bytes.

The arithmetic is purely combinational and is followed by one register stage. A request presented with `in_valid` high appears on the outputs one clock later. The registered results hold while no new request arrives. Fetching the group and comparing its entries is left to the logic downstream.

Top module: `hpt_index_gen`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. The registered outputs load only on a cycle with `in_valid` high and keep their values otherwise.
- R2: While `rst_n` is low, every output is zero.
- R3: With `seg_large`=0 (256 MB segment), `vpn` = (`vsid` << 16) | `ea`[27:12], truncated to 64 bits.
- R4: With `seg_large`=1 (1 TB segment), `vpn` = (`vsid` << 28) | `ea`[39:12], truncated to 64 bits.
- R5: For a 256 MB segment, the primary hash = (`vpn` >> 16) XOR ((`vpn` & 0xFFFF) >> (`pg_shift` − 12)).
- R6: For a 1 TB segment, with u = `vpn` >> 28, the primary hash = u XOR (u << 25) XOR ((`vpn` & 0xFFFFFFF) >> (`pg_shift` − 12)), with each term taken at 64 bits.
- R7: `hash_pri` is the low 39 bits of the R5/R6 result; higher bits are discarded.
- R8: `hash_sec` is the bitwise complement of `hash_pri` over its 39 bits.
- R9: `grp_index` = `hash_pri` & `tbl_mask`, and `grp_offset` = `grp_index` × 128.
- R10: A `pg_shift` outside {12, 16, 24} sets `shift_err` and forces `hash_pri`, `hash_sec`, `grp_index` and `grp_offset` to zero. `vpn` is still formed per R3/R4. A legal code clears `shift_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; inputs are captured on this cycle |
| vsid | input | 40 | Segment virtual identifier |
| ea | input | 64 | Effective address |
| seg_large | input | 1 | 0 = 256 MB segment, 1 = 1 TB segment |
| pg_shift | input | 6 | Base-2 log of the page size (12, 16 or 24) |
| tbl_mask | input | 39 | Table-size mask applied to the primary hash |
| out_valid | output | 1 | Registered results are fresh |
| vpn | output | 64 | Virtual page number with 12 bits dropped |
| hash_pri | output | 39 | Primary hash |
| hash_sec | output | 39 | Secondary hash |
| grp_index | output | 39 | Masked group index |
| grp_offset | output | 46 | Byte offset of the group within the table |
| shift_err | output | 1 | Illegal page-shift code |

## Verification
The bench sweeps both segment sizes against every legal page shift and three illegal ones. Each combination is driven with all-zero and all-ones operands, pseudo-random operands, and several table masks, and the expected values are computed with plain 64-bit arithmetic.

All-ones identifiers expose a design that fails to truncate the shifted identifier or the 25-bit mix, because its hash bits above bit 38 or its VPN would differ. Mixing up the segment-size formulas or the page-offset drop per page size shows up as wrong hashes at the 64K and 16M shifts. Illegal shift codes catch a design that lets garbage through instead of zeroing the hash outputs. Idle cycles with changed inputs reveal a register stage that loads without a request.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int PG_BASE = 12;

  typedef enum logic [1:0] {
    PGC_4K  = 2'd0,
    PGC_64K = 2'd1,
    PGC_16M = 2'd2,
    PGC_BAD = 2'd3
  } pg_cls_e;

  // page shift belonging to a legal page class index
  function automatic int cls_shift(input int k);
    case (k)
      0:       return 12;
      1:       return 16;
      default: return 24;
    endcase
  endfunction

  // number of low VPN bits dropped from the page-offset term
  function automatic int cls_drop(input int k);
    return cls_shift(k) - PG_BASE;
  endfunction

  function automatic pg_cls_e classify(input logic [5:0] s);
    pg_cls_e c;
    c = PGC_BAD;
    for (int k = 0; k < 3; k++) begin
      if (s == 6'(cls_shift(k))) c = pg_cls_e'(k);
    end
    return c;
  endfunction

endpackage

// File: rtl/hpt_vpn_build.sv
module hpt_vpn_build #(
  parameter int VSID_W      = 40,
  parameter int EA_W        = 64,
  parameter int VPN_W       = 64,
  parameter int SEG_S_SHIFT = 28,
  parameter int SEG_L_SHIFT = 40
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [EA_W-1:0]   ea,
  input  logic              seg_large,
  output logic [VPN_W-1:0]  vpn
);
  localparam int S_BITS = SEG_S_SHIFT - hpt_pkg::PG_BASE;
  localparam int L_BITS = SEG_L_SHIFT - hpt_pkg::PG_BASE;
  localparam logic [VPN_W-1:0] S_MASK = (VPN_W'(1) << S_BITS) - VPN_W'(1);
  localparam logic [VPN_W-1:0] L_MASK = (VPN_W'(1) << L_BITS) - VPN_W'(1);

  function automatic logic [VPN_W-1:0] join_id(
    input logic [VSID_W-1:0] id,
    input logic [EA_W-1:0]   addr,
    input int                bits,
    input logic [VPN_W-1:0]  msk
  );
    logic [VPN_W-1:0] pg;
    pg = VPN_W'(addr >> hpt_pkg::PG_BASE);
    return (VPN_W'(id) << bits) | (pg & msk);
  endfunction

  logic [VPN_W-1:0] vpn_small;
  logic [VPN_W-1:0] vpn_large;

  assign vpn_small = join_id(vsid, ea, S_BITS, S_MASK);
  assign vpn_large = join_id(vsid, ea, L_BITS, L_MASK);
  assign vpn       = seg_large ? vpn_large : vpn_small;

endmodule

// File: rtl/hpt_hash_core.sv
module hpt_hash_core #(
  parameter int VPN_W       = 64,
  parameter int HASH_W      = 39,
  parameter int SEG_S_SHIFT = 28,
  parameter int SEG_L_SHIFT = 40,
  parameter int MIX_SHIFT   = 25
) (
  input  logic [VPN_W-1:0]     vpn,
  input  logic                 seg_large,
  input  hpt_pkg::pg_cls_e     cls,
  output logic [HASH_W-1:0]    hash_pri,
  output logic [HASH_W-1:0]    hash_sec
);
  localparam int S_BITS = SEG_S_SHIFT - hpt_pkg::PG_BASE;
  localparam int L_BITS = SEG_L_SHIFT - hpt_pkg::PG_BASE;
  localparam logic [VPN_W-1:0] S_MASK = (VPN_W'(1) << S_BITS) - VPN_W'(1);
  localparam logic [VPN_W-1:0] L_MASK = (VPN_W'(1) << L_BITS) - VPN_W'(1);

  // page-offset terms, one per legal page class
  logic [VPN_W-1:0] low_s [3];
  logic [VPN_W-1:0] low_l [3];

  for (genvar k = 0; k < 3; k++) begin : g_cls
    localparam int DROP = hpt_pkg::cls_drop(k);
    assign low_s[k] = (vpn & S_MASK) >> DROP;
    assign low_l[k] = (vpn & L_MASK) >> DROP;
  end

  function automatic logic [HASH_W-1:0] fold_small(
    input logic [VPN_W-1:0] v,
    input logic [VPN_W-1:0] low
  );
    return HASH_W'((v >> S_BITS) ^ low);
  endfunction

  function automatic logic [HASH_W-1:0] fold_large(
    input logic [VPN_W-1:0] v,
    input logic [VPN_W-1:0] low
  );
    logic [VPN_W-1:0] id;
    id = v >> L_BITS;
    return HASH_W'(id ^ (id << MIX_SHIFT) ^ low);
  endfunction

  logic [VPN_W-1:0] low_sel_s;
  logic [VPN_W-1:0] low_sel_l;
  logic             cls_bad;

  always_comb begin
    cls_bad   = 1'b0;
    low_sel_s = low_s[0];
    low_sel_l = low_l[0];
    unique case (cls)
      hpt_pkg::PGC_4K:  begin low_sel_s = low_s[0]; low_sel_l = low_l[0]; end
      hpt_pkg::PGC_64K: begin low_sel_s = low_s[1]; low_sel_l = low_l[1]; end
      hpt_pkg::PGC_16M: begin low_sel_s = low_s[2]; low_sel_l = low_l[2]; end
      default:          cls_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (cls_bad) begin
      hash_pri = '0;
      hash_sec = '0;
    end else begin
      hash_pri = seg_large ? fold_large(vpn, low_sel_l) : fold_small(vpn, low_sel_s);
      hash_sec = ~hash_pri;
    end
  end

endmodule

// File: rtl/hpt_group_sel.sv
module hpt_group_sel #(
  parameter int HASH_W   = 39,
  parameter int GRP_LOG  = 7
) (
  input  logic [HASH_W-1:0]         hash,
  input  logic [HASH_W-1:0]         tbl_mask,
  output logic [HASH_W-1:0]         index,
  output logic [HASH_W+GRP_LOG-1:0] offset
);
  assign index  = hash & tbl_mask;
  assign offset = {index, {GRP_LOG{1'b0}}};
endmodule

// File: rtl/hpt_index_gen.sv
module hpt_index_gen #(
  parameter int VSID_W          = 40,
  parameter int EA_W            = 64,
  parameter int VPN_W           = 64,
  parameter int HASH_W          = 39,
  parameter int SEG_S_SHIFT     = 28,
  parameter int SEG_L_SHIFT     = 40,
  parameter int MIX_SHIFT       = 25,
  parameter int ENTRIES_PER_GRP = 8,
  parameter int WORDS_PER_ENTRY = 2,
  parameter int WORD_BYTES      = 8,
  localparam int GRP_LOG = $clog2(ENTRIES_PER_GRP * WORDS_PER_ENTRY * WORD_BYTES),
  localparam int OFS_W   = HASH_W + GRP_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VSID_W-1:0] vsid,
  input  logic [EA_W-1:0]   ea,
  input  logic              seg_large,
  input  logic [5:0]        pg_shift,
  input  logic [HASH_W-1:0] tbl_mask,
  output logic              out_valid,
  output logic [VPN_W-1:0]  vpn,
  output logic [HASH_W-1:0] hash_pri,
  output logic [HASH_W-1:0] hash_sec,
  output logic [HASH_W-1:0] grp_index,
  output logic [OFS_W-1:0]  grp_offset,
  output logic              shift_err
);

  // named internal events
  hpt_pkg::pg_cls_e  cls_c;
  logic              bad_c;
  logic              capture;
  logic [VPN_W-1:0]  vpn_c;
  logic [HASH_W-1:0] pri_c;
  logic [HASH_W-1:0] sec_c;
  logic [HASH_W-1:0] idx_c;
  logic [OFS_W-1:0]  ofs_c;

  assign cls_c   = hpt_pkg::classify(pg_shift);
  assign bad_c   = (cls_c == hpt_pkg::PGC_BAD);
  assign capture = in_valid;

  hpt_vpn_build #(
    .VSID_W(VSID_W), .EA_W(EA_W), .VPN_W(VPN_W),
    .SEG_S_SHIFT(SEG_S_SHIFT), .SEG_L_SHIFT(SEG_L_SHIFT)
  ) u_vpn (
    .vsid(vsid), .ea(ea), .seg_large(seg_large), .vpn(vpn_c)
  );

  hpt_hash_core #(
    .VPN_W(VPN_W), .HASH_W(HASH_W),
    .SEG_S_SHIFT(SEG_S_SHIFT), .SEG_L_SHIFT(SEG_L_SHIFT), .MIX_SHIFT(MIX_SHIFT)
  ) u_hash (
    .vpn(vpn_c), .seg_large(seg_large), .cls(cls_c),
    .hash_pri(pri_c), .hash_sec(sec_c)
  );

  hpt_group_sel #(
    .HASH_W(HASH_W), .GRP_LOG(GRP_LOG)
  ) u_grp (
    .hash(pri_c), .tbl_mask(tbl_mask), .index(idx_c), .offset(ofs_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      vpn        <= '0;
      hash_pri   <= '0;
      hash_sec   <= '0;
      grp_index  <= '0;
      grp_offset <= '0;
      shift_err  <= 1'b0;
    end else begin
      out_valid <= capture;
      if (capture) begin
        vpn        <= vpn_c;
        hash_pri   <= pri_c;
        hash_sec   <= sec_c;
        grp_index  <= idx_c;
        grp_offset <= ofs_c;
        shift_err  <= bad_c;
      end
    end
  end

endmodule

// File: rtl/hpt_index_gen_chk.sv
module hpt_index_gen_chk #(
  parameter int VPN_W  = 64,
  parameter int HASH_W = 39,
  parameter int OFS_W  = 46
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [5:0]        pg_shift,
  input logic [HASH_W-1:0] tbl_mask,
  input logic              out_valid,
  input logic [VPN_W-1:0]  vpn,
  input logic [HASH_W-1:0] hash_pri,
  input logic [HASH_W-1:0] hash_sec,
  input logic [HASH_W-1:0] grp_index,
  input logic [OFS_W-1:0]  grp_offset,
  input logic              shift_err
);
  logic legal_ps;
  assign legal_ps = (pg_shift == 6'd12) || (pg_shift == 6'd16) || (pg_shift == 6'd24);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(vpn) && $stable(hash_pri) && $stable(grp_offset) && $stable(shift_err))); // R1
  AST_SEC_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !shift_err) |-> (hash_sec == ~hash_pri)); // R8
  AST_INDEX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (grp_index == (hash_pri & $past(tbl_mask)))); // R9
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal_ps) |=> shift_err); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal_ps) |=> !shift_err); // R10
  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    shift_err |-> (hash_pri == '0 && hash_sec == '0 && grp_offset == '0)); // R10

endmodule

bind hpt_index_gen hpt_index_gen_chk #(
  .VPN_W(VPN_W), .HASH_W(HASH_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/hpt_index_gen_bench.sv
module hpt_index_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned M39 = (64'd1 << 39) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] vsid = '0;
  logic [63:0] ea = '0;
  logic        seg_large = 1'b0;
  logic [5:0]  pg_shift = 6'd12;
  logic [38:0] tbl_mask = '0;
  logic        out_valid;
  logic [63:0] vpn;
  logic [38:0] hash_pri, hash_sec, grp_index;
  logic [45:0] grp_offset;
  logic        shift_err;

  int n_chk = 0;
  int n_fail = 0;
  longint unsigned rng = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_index_gen u_hpt_index_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vsid(vsid), .ea(ea),
    .seg_large(seg_large), .pg_shift(pg_shift), .tbl_mask(tbl_mask),
    .out_valid(out_valid), .vpn(vpn), .hash_pri(hash_pri), .hash_sec(hash_sec),
    .grp_index(grp_index), .grp_offset(grp_offset), .shift_err(shift_err)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint unsigned next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 7;
    rng ^= rng << 17;
    return rng;
  endfunction

  // arithmetic restatement of R3..R10
  longint unsigned e_vpn, e_pri, e_sec, e_idx, e_ofs;
  bit              e_err;

  task automatic model(input longint unsigned id, input longint unsigned adr,
                       input bit lg, input int ps, input longint unsigned msk);
    longint unsigned u, h;
    if (lg) e_vpn = (id << 28) | ((adr >> 12) & 64'hFFF_FFFF);   // R4
    else    e_vpn = (id << 16) | ((adr >> 12) & 64'hFFFF);       // R3
    e_err = !(ps == 12 || ps == 16 || ps == 24);
    if (e_err) h = 0;
    else if (lg) begin
      u = e_vpn >> 28;
      h = u ^ (u << 25) ^ ((e_vpn & 64'hFFF_FFFF) >> (ps - 12)); // R6
    end else begin
      h = (e_vpn >> 16) ^ ((e_vpn & 64'hFFFF) >> (ps - 12));     // R5
    end
    e_pri = h & M39;                                             // R7
    e_sec = e_err ? 0 : (~e_pri) & M39;                          // R8
    e_idx = e_pri & msk;                                         // R9
    e_ofs = e_idx * 128;
  endtask

  task automatic check_out(input bit lg);
    chk(out_valid == 1'b1, "R1 out_valid", 64'(out_valid), 1);
    chk(vpn == e_vpn, lg ? "R4 vpn" : "R3 vpn", vpn, e_vpn);
    chk(64'(hash_pri) == e_pri, lg ? "R6/R7 hash_pri" : "R5/R7 hash_pri", 64'(hash_pri), e_pri);
    chk(64'(hash_sec) == e_sec, "R8 hash_sec", 64'(hash_sec), e_sec);
    chk(64'(grp_index) == e_idx, "R9 grp_index", 64'(grp_index), e_idx);
    chk(64'(grp_offset) == e_ofs, "R9 grp_offset", 64'(grp_offset), e_ofs);
    chk(shift_err == e_err, "R10 shift_err", 64'(shift_err), 64'(e_err));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int ps_list[6];
    longint unsigned masks[4];
    ps_list = '{12, 16, 24, 0, 13, 63};
    masks = '{M39, 64'h3FF, 64'h0, 64'h55_5555_5555};

    // R2: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && vpn == 0 && hash_pri == 0 && hash_sec == 0 &&
        grp_index == 0 && grp_offset == 0 && shift_err == 0,
        "R2 reset outputs", vpn, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int lg = 0; lg < 2; lg++) begin
      for (int p = 0; p < 6; p++) begin
        for (int n = 0; n < 40; n++) begin
          longint unsigned id, adr;
          if (n == 0) begin id = 0; adr = 0; end
          else if (n == 1) begin id = 64'hFF_FFFF_FFFF; adr = '1; end
          else begin id = next_rand() & 64'hFF_FFFF_FFFF; adr = next_rand(); end
          vsid      = id[39:0];
          ea        = adr;
          seg_large = lg[0];
          pg_shift  = 6'(ps_list[p]);
          tbl_mask  = masks[n % 4][38:0];
          in_valid  = 1'b1;
          model(id, adr, lg[0], ps_list[p], masks[n % 4]);
          @(negedge clk);
          check_out(lg[0]);
        end
      end
    end

    // R1: idle cycles with changed inputs keep the last result
    begin
      longint unsigned h_vpn, h_pri;
      h_vpn = vpn; h_pri = 64'(hash_pri);
      in_valid = 1'b0;
      vsid = 40'h12_3456_789A; ea = 64'hDEAD_BEEF_0000_1000; pg_shift = 6'd16;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 idle out_valid", 64'(out_valid), 0);
      chk(vpn == h_vpn, "R1 idle vpn hold", vpn, h_vpn);
      chk(64'(hash_pri) == h_pri, "R1 idle hash hold", 64'(hash_pri), h_pri);
      @(negedge clk);
      chk(vpn == h_vpn, "R1 second idle vpn hold", vpn, h_vpn);
    end

    // R10 then legal code: error flag clears on the next request
    in_valid = 1'b1; seg_large = 1'b1; pg_shift = 6'd20; tbl_mask = '1;
    model(64'(vsid), ea, 1'b1, 20, M39);
    @(negedge clk);
    check_out(1'b1);
    pg_shift = 6'd24;
    model(64'(vsid), ea, 1'b1, 24, M39);
    @(negedge clk);
    check_out(1'b1);
    in_valid = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule